// File: doc/BRIEF.md
# Byte FIFO Bridge with Word Data Register and Error Interrupt

This block connects a parallel-port pin engine, which moves one byte per transfer, to a 32-bit register port used by software or a DMA engine. A shared byte FIFO (8 entries by default) carries data in the direction chosen by a mode input. In receive mode the pin engine pushes bytes and a read of the data register pops up to four at once. In transmit mode a write of the data register pushes up to four bytes and the pin engine pops them one at a time.

Two readiness flags in the status word report whether one or four bytes can be moved. Their meaning follows the direction: filled bytes when receiving, free slots when transmitting. The FIFO is emptied while the block is disabled. A single sticky error bit records an overrun when receiving or an underrun when transmitting. It has an enable mask, a masked view, a write-one-to-clear register and an interrupt output.

Top module: `byte_word_fifo`

## Requirements
- R1: The data register at byte offset 40 packs four bytes with the oldest in bits 7:0, then bits 15:8, 23:16 and 31:24. A receive-mode read pops them in that order, and a transmit-mode write pushes bits 7:0 first.
- R2: In receive mode, status (offset 4) bit 2 is 1 when at least four bytes are buffered, and bit 3 is 1 when at least one byte is buffered. The other status bits read 0.
- R3: In transmit mode, status bit 2 is 1 when at least four of the 8 slots are free, and bit 3 is 1 when at least one slot is free.
- R4: While `enable_i` is 0, the FIFO is held empty one cycle later. Pin pushes, pin pops and data-register accesses have no effect and raise no error.
- R5: In receive mode, a pin push while 8 bytes are buffered sets the raw error bit (offset 8, bit 1), and the byte is dropped.
- R6: In transmit mode, a pin pop while the FIFO is empty sets the raw error bit. In that cycle `pin_data_o` reads 0, and it reads 0 whenever the FIFO is empty or the block is in receive mode.
- R7: The raw error bit stays set until a write to offset 20 with bit 1 set. If an error event and that clear happen in the same cycle, the bit stays set.
- R8: The interrupt enable bit (offset 12, bit 1) is read/write. The masked status (offset 16, bit 1) equals raw AND enable, and `irq_o` equals the masked status.
- R9: A receive read with fewer than four bytes buffered returns zeros in the unfilled upper bytes and pops only the bytes present, without error. A transmit write with fewer than four free slots pushes only the low bytes that fit. A data read in transmit mode returns 0.
- R10: Bytes leave the FIFO in the order they entered it, across pointer wrap and mixed one-byte and four-byte transfers. Offsets 0, 20 and all unlisted offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; FIFO flushed while low |
| tx_mode_i | input | 1 | 1 = transmit (register to pins), 0 = receive |
| pin_push_i | input | 1 | Pin engine pushes `pin_data_i` (receive) |
| pin_data_i | input | 8 | Byte from the pin engine |
| pin_pop_i | input | 1 | Pin engine takes `pin_data_o` (transmit) |
| pin_data_o | output | 8 | Oldest byte toward the pin engine |
| reg_rd_i | input | 1 | Register read strobe; pops on the data register |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Error interrupt |

## Verification
Directed sequences fill the receive FIFO to 5, 1, 0 and 8 bytes and read it back. These cases separate the four-byte threshold from the one-byte threshold, and full-word reads from short reads. Transmit sequences drain a full FIFO through the pin port and then pop once more. This tells underrun apart from a normal pop, and free-slot flags apart from fill flags. A cycle that raises an error together with a clear write checks which one takes priority. A long seeded random mix of pushes, pops, register accesses and enable drops then compares every byte, flag and interrupt level against a queue model. That run exercises wrap-around and flushes in the middle of traffic.

// File: rtl/bfb_pkg.sv
package bfb_pkg;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] OFS_STATUS = 6'd4;
  localparam logic [REG_AW-1:0] OFS_RAW    = 6'd8;
  localparam logic [REG_AW-1:0] OFS_IEN    = 6'd12;
  localparam logic [REG_AW-1:0] OFS_MASKED = 6'd16;
  localparam logic [REG_AW-1:0] OFS_CLEAR  = 6'd20;
  localparam logic [REG_AW-1:0] OFS_DATA   = 6'd40;

  localparam int unsigned ERR_BIT   = 1;
  localparam int unsigned RDY4_BIT  = 2;
  localparam int unsigned RDY1_BIT  = 3;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/bfb_ring.sv
// Byte ring with multi-byte push and pop per cycle. DEPTH must be a power of two >= LANES.
module bfb_ring
  import bfb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned PTR_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned LANE_W = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [LANE_W-1:0]       push_n_i,
  input  byte_t [LANES-1:0]       push_data_i,
  input  logic [LANE_W-1:0]       pop_n_i,
  output byte_t [LANES-1:0]       peek_o,
  output logic [CNT_W-1:0]        count_o
);
  byte_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (!flush_i && k < int'(push_n_i)) mem_q[wr_ptr_q + PTR_W'(k)] <= push_data_i[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(push_n_i);
      rd_ptr_q <= rd_ptr_q + PTR_W'(pop_n_i);
      count_q  <= count_q + CNT_W'(push_n_i) - CNT_W'(pop_n_i);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    logic [PTR_W-1:0] idx;
    assign idx       = rd_ptr_q + PTR_W'(k);
    assign peek_o[k] = mem_q[idx];
  end

  assign count_o = count_q;

  // R10: fill level never exceeds capacity
  assert_count_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  // R9: a pop never asks for more than is buffered
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |-> CNT_W'(pop_n_i) <= count_q);
endmodule

// File: rtl/bfb_err.sv
module bfb_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_wr_i,
  input  logic ien_d_i,
  output logic raw_o,
  output logic ien_o,
  output logic irq_o
);
  logic raw_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (set_i)      raw_q <= 1'b1;   // set beats clear
      else if (clr_i) raw_q <= 1'b0;
      if (ien_wr_i)   ien_q <= ien_d_i;
    end
  end

  assign raw_o = raw_q;
  assign ien_o = ien_q;
  assign irq_o = raw_q & ien_q;

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_q && !clr_i |=> raw_q);
  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> raw_q);
  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !raw_q);
  assert_ien_wr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_wr_i |=> ien_q == $past(ien_d_i));
endmodule

// File: rtl/byte_word_fifo.sv
module byte_word_fifo
  import bfb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned LANE_W = $clog2(LANES + 1),
  localparam int unsigned WORD_W = 8 * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tx_mode_i,
  input  logic              pin_push_i,
  input  logic [7:0]        pin_data_i,
  input  logic              pin_pop_i,
  output logic [7:0]        pin_data_o,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  count, free;
  logic [LANE_W-1:0] fill_lanes, free_lanes, push_n, pop_n;
  byte_t [LANES-1:0] peek, push_data, rd_bytes;
  logic              rx_en, tx_en, dr_rd, dr_wr;
  logic              err_set, err_clr, ien_wr, raw, ien, rdy4, rdy1;

  assign rx_en = enable_i && !tx_mode_i;
  assign tx_en = enable_i &&  tx_mode_i;
  assign dr_rd = reg_rd_i && reg_addr_i == OFS_DATA;
  assign dr_wr = reg_wr_i && reg_addr_i == OFS_DATA;

  assign free       = CNT_W'(DEPTH) - count;
  assign fill_lanes = (count >= CNT_W'(LANES)) ? LANE_W'(LANES) : LANE_W'(count);
  assign free_lanes = (free  >= CNT_W'(LANES)) ? LANE_W'(LANES) : LANE_W'(free);

  always_comb begin
    push_n    = '0;
    pop_n     = '0;
    push_data = reg_wdata_i;
    err_set   = 1'b0;
    if (rx_en) begin
      push_data[0] = pin_data_i;
      if (pin_push_i) begin
        if (count < CNT_W'(DEPTH)) push_n = LANE_W'(1);
        else                       err_set = 1'b1;
      end
      if (dr_rd) pop_n = fill_lanes;
    end else if (tx_en) begin
      if (dr_wr) push_n = free_lanes;
      if (pin_pop_i) begin
        if (count != '0) pop_n = LANE_W'(1);
        else             err_set = 1'b1;
      end
    end
  end

  bfb_ring #(.DEPTH(DEPTH), .LANES(LANES)) i_ring (
    .clk_i, .rst_ni,
    .flush_i     (!enable_i),
    .push_n_i    (push_n),
    .push_data_i (push_data),
    .pop_n_i     (pop_n),
    .peek_o      (peek),
    .count_o     (count)
  );

  assign err_clr = reg_wr_i && reg_addr_i == OFS_CLEAR && reg_wdata_i[ERR_BIT];
  assign ien_wr  = reg_wr_i && reg_addr_i == OFS_IEN;

  bfb_err i_err (
    .clk_i, .rst_ni,
    .set_i    (err_set),
    .clr_i    (err_clr),
    .ien_wr_i (ien_wr),
    .ien_d_i  (reg_wdata_i[ERR_BIT]),
    .raw_o    (raw),
    .ien_o    (ien),
    .irq_o    (irq_o)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    assign rd_bytes[k] = (rx_en && LANE_W'(k) < fill_lanes) ? peek[k] : 8'h00;
  end

  assign rdy4 = tx_mode_i ? free  >= CNT_W'(LANES) : count >= CNT_W'(LANES);
  assign rdy1 = tx_mode_i ? free  != '0             : count != '0;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_STATUS: begin
        reg_rdata_o[RDY4_BIT] = rdy4;
        reg_rdata_o[RDY1_BIT] = rdy1;
      end
      OFS_RAW:    reg_rdata_o[ERR_BIT] = raw;
      OFS_IEN:    reg_rdata_o[ERR_BIT] = ien;
      OFS_MASKED: reg_rdata_o[ERR_BIT] = raw & ien;
      OFS_DATA:   reg_rdata_o = rd_bytes;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign pin_data_o = (tx_en && count != '0) ? peek[0] : 8'h00;

  assert_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> count == '0);
  assert_overrun_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en && pin_push_i && count == CNT_W'(DEPTH) |=> raw);
  assert_underrun_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en && pin_pop_i && count == '0 |=> raw);
  assert_no_err_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i && !raw |=> !raw);
endmodule

// File: tb/test_byte_word_fifo.sv
module test_byte_word_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable, tx_mode, pin_push, pin_pop, reg_rd, reg_wr;
  logic [7:0]  pin_din;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [7:0]  pin_dout;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [7:0] q[$];
  bit m_en = 0, m_tx = 0, m_raw = 0, m_ien = 0;

  always #5 clk = ~clk;

  byte_word_fifo i_byte_word_fifo (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .tx_mode_i(tx_mode),
    .pin_push_i(pin_push), .pin_data_i(pin_din), .pin_pop_i(pin_pop),
    .pin_data_o(pin_dout), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [5:0] a);
    logic [31:0] r = '0;
    int n = q.size();
    case (a)
      6'd4: begin
        r[2] = m_tx ? (8 - n) >= 4 : n >= 4;
        r[3] = m_tx ? (8 - n) >= 1 : n >= 1;
      end
      6'd8:  r[1] = m_raw;
      6'd12: r[1] = m_ien;
      6'd16: r[1] = m_raw & m_ien;
      6'd40: if (m_en && !m_tx) for (int k = 0; k < 4 && k < n; k++) r[8*k +: 8] = q[k];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic step(input bit push, input bit pop, input bit rd, input bit wr,
                      input logic [5:0] a, input logic [31:0] wd, input logic [7:0] pd,
                      input string tag);
    bit set = 0;
    int n;
    @(negedge clk);
    enable = m_en; tx_mode = m_tx; pin_push = push; pin_pop = pop;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; pin_din = pd;
    #1;
    if (rd) chk(reg_rdata, exp_rdata(a), tag);
    chk({24'b0, pin_dout}, (m_en && m_tx && q.size() > 0) ? {24'b0, q[0]} : 32'b0, tag);
    chk({31'b0, irq}, {31'b0, m_raw & m_ien}, tag);
    n = q.size();
    if (!m_en) q.delete();
    else if (!m_tx) begin
      if (rd && a == 6'd40) for (int k = 0; k < 4 && k < n; k++) void'(q.pop_front());
      if (push) begin
        if (n < 8) q.push_back(pd);
        else set = 1;
      end
    end else begin
      if (pop) begin
        if (n > 0) void'(q.pop_front());
        else set = 1;
      end
      if (wr && a == 6'd40) for (int k = 0; k < 4 && k < 8 - n; k++) q.push_back(wd[8*k +: 8]);
    end
    if (set) m_raw = 1;
    else if (wr && a == 6'd20 && wd[1]) m_raw = 0;
    if (wr && a == 6'd12) m_ien = wd[1];
  endtask

  task automatic rd_reg(input logic [5:0] a, input string tag);
    step(0, 0, 1, 0, a, '0, '0, tag);
  endtask
  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d, input string tag);
    step(0, 0, 0, 1, a, d, '0, tag);
  endtask
  task automatic push_b(input logic [7:0] d, input string tag);
    step(1, 0, 0, 0, '0, '0, d, tag);
  endtask
  task automatic pop_b(input string tag);
    step(0, 1, 0, 0, '0, '0, '0, tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    enable = 0; tx_mode = 0; pin_push = 0; pin_pop = 0; reg_rd = 0; reg_wr = 0;
    reg_addr = '0; reg_wdata = '0; pin_din = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // reset state
    rd_reg(6'd4,  "R2 reset status");
    rd_reg(6'd8,  "R7 reset raw");
    rd_reg(6'd12, "R8 reset ien");
    rd_reg(6'd0,  "R10 offset 0");
    // receive thresholds and packing
    m_en = 1;
    for (int i = 1; i <= 5; i++) push_b(8'hA0 + 8'(i), "R2 fill");
    rd_reg(6'd4,  "R2 five buffered");
    rd_reg(6'd40, "R1 word read");
    rd_reg(6'd4,  "R2 one buffered");
    rd_reg(6'd40, "R9 short read");
    rd_reg(6'd4,  "R2 empty");
    rd_reg(6'd40, "R9 empty read");
    rd_reg(6'd8,  "R9 no error on short read");
    // overrun
    for (int i = 0; i < 9; i++) push_b(8'h10 + 8'(i), "R5 fill");
    rd_reg(6'd8,  "R5 overrun raw");
    rd_reg(6'd16, "R8 masked off");
    wr_reg(6'd12, 32'h2, "R8 ien write");
    rd_reg(6'd16, "R8 masked on");
    rd_reg(6'd12, "R8 ien read");
    step(1, 0, 0, 1, 6'd20, 32'h2, 8'hEE, "R7 set beats clear");
    rd_reg(6'd8,  "R7 still set");
    wr_reg(6'd20, 32'h1, "R7 wrong bit");
    rd_reg(6'd8,  "R7 wrong bit no clear");
    wr_reg(6'd20, 32'h2, "R7 clear");
    rd_reg(6'd8,  "R7 cleared");
    rd_reg(6'd40, "R10 order");
    rd_reg(6'd40, "R10 order 2");
    rd_reg(6'd20, "R10 clear reads 0");
    // disable flushes
    for (int i = 0; i < 6; i++) push_b(8'h30 + 8'(i), "R4 fill");
    m_en = 0;
    push_b(8'h55, "R4 push ignored");
    for (int i = 0; i < 9; i++) push_b(8'h56, "R4 no overrun");
    rd_reg(6'd8,  "R4 no error disabled");
    m_en = 1;
    rd_reg(6'd4,  "R4 flushed");
    rd_reg(6'd40, "R4 flushed read");
    // transmit
    m_en = 0; rd_reg(6'd4, "R3 idle"); m_tx = 1; m_en = 1;
    rd_reg(6'd4,  "R3 all free");
    wr_reg(6'd40, 32'h44332211, "R1 word write");
    rd_reg(6'd4,  "R3 four free");
    wr_reg(6'd40, 32'h88776655, "R3 fill");
    rd_reg(6'd4,  "R3 none free");
    wr_reg(6'd40, 32'hDEADBEEF, "R9 write dropped");
    rd_reg(6'd40, "R9 tx read zero");
    pop_b("R1 byte order");
    pop_b("R1 byte order");
    pop_b("R1 byte order");
    rd_reg(6'd4,  "R3 three free");
    wr_reg(6'd40, 32'hCCBBAA99, "R9 short write");
    for (int i = 0; i < 9; i++) pop_b("R10 tx drain");
    rd_reg(6'd8,  "R6 underrun");
    pop_b("R6 underrun data zero");
    wr_reg(6'd20, 32'h2, "R7 clear");
    // random
    m_en = 0; m_tx = 0;
    rd_reg(6'd8, "R7 cleared tx");
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [5:0] a;
      case ($urandom_range(0, 7))
        0: a = 6'd4; 1: a = 6'd8; 2: a = 6'd12; 3: a = 6'd16; 4: a = 6'd20;
        default: a = 6'd40;
      endcase
      if (r < 2) m_en = 0;
      else if (r < 6) begin
        if (!m_en) m_tx = $urandom_range(0, 1) == 1;
        m_en = 1;
      end
      step($urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           a, $urandom, 8'($urandom), "R10 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h1234));
endmodule